// File: doc/BRIEF.md
# Sectioned Register File Access Controller

This block is the byte-level back half of a two-wire serial slave. A bit-level engine in front of it decodes bus traffic into single-cycle events: start (also repeated start), stop, the device-address byte, a received write byte, and a request for the next read byte. The controller decides whether the device address selects it. It then moves a byte pointer through one of two address spaces. The first is a 48-byte register map split into fixed sections. The second is a separate general-purpose byte memory with its own device address.

In a write transfer, the first data byte loads the pointer and every later byte is stored. In a read transfer, bytes come from the current pointer. The pointer moves one step per byte but never leaves the section it started in: after the last address of a section it returns to that section's first address.

The seven clock registers have two special rules:
- Host writes to them are discarded unless a protect-release bit in the control section is set.
- A read transfer that begins in the clock or alarm section first copies all seven clock registers into a shadow. The burst then returns a consistent time even while the calendar logic keeps updating them.

Top module: `secreg_ctrl`

## Requirements
- R1: A device-address byte received after a start is acknowledged (o_dev_ack high in that same cycle) when bits 7:1 equal 1101111 (register map) or 1010111 (byte memory); bit 0 set means read. Any other address is not acknowledged, and later write bytes and read requests in that transfer change no storage, no pointer and no output.
- R2: In a write transfer, the first data byte loads the pointer (all 8 bits for the register map, the low log2(MEM_DEPTH) bits for the memory). Each later byte is stored at the pointer, and the pointer then advances.
- R3: The register map sections are 00h-06h (clock), 07h-0Fh (control), 10h-15h (alarm), 16h-1Ah, 1Bh-1Fh, 20h-27h, 28h-29h, 2Ah-2Fh, plus 30h-FFh as an unmapped range. After the last address of a section, the pointer goes to the first address of the same section, for reads and for writes.
- R4: A host write to 00h-06h takes effect only while bit 6 of register 08h is 1. Otherwise the byte is accepted and discarded, and the pointer still advances. Other addresses need no enable.
- R5: A register-map read whose device-address byte arrives with the pointer in 00h-06h or 10h-15h copies registers 00h-06h into a shadow. Until the next start or stop, reads of 00h-06h return the shadow, unaffected by calendar updates.
- R6: Each space keeps its pointer across transfers. After a transfer ends, the pointer is the last address used plus one (with the R3 wrap), so a read that sends no pointer byte continues from there.
- R7: Reads at 30h-FFh return 00h, and writes there are discarded.
- R8: The byte memory has MEM_DEPTH bytes and its own pointer. That pointer wraps from the top address to 0, and memory writes need no enable. Transfers to one space leave the other space's pointer unchanged.
- R9: The calendar port writes any of registers 00h-06h regardless of the protect bit. Reads made outside a snapshot return the new value.
- R10: o_rd_byte is 00h after reset. It changes only on the clock edge that accepts a read request, and after that edge it holds the addressed byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_start | input | 1 | Start or repeated-start event |
| i_stop | input | 1 | Stop event |
| i_dev_vld | input | 1 | Device-address byte valid |
| i_dev_byte | input | 8 | Device-address byte (bit 0 = read) |
| o_dev_ack | output | 1 | Device address selects this block |
| i_wr_vld | input | 1 | Received write byte valid |
| i_wr_byte | input | 8 | Received write byte |
| i_rd_req | input | 1 | Request for the next read byte |
| o_rd_byte | output | 8 | Read byte, registered |
| i_cal_we | input | 1 | Calendar update strobe |
| i_cal_idx | input | $clog2(CLK_REGS) | Clock register index to update |
| i_cal_byte | input | 8 | Calendar update value |

## Verification
The hardest case to reach is a calendar update that lands in the middle of a clock-register read burst. The stimulus sets the pointer to 00h and opens the read. It then pulses the calendar port between individual read requests, on bytes not yet read and on bytes already read. The bench model expects the pre-update values to the end of that burst and the new values in the next transfer. A second hard case is reaching a section's last address with the protect bit in each state, so that the wrap and the discard rules are exercised together.

// File: rtl/secreg_pkg.sv
package secreg_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_DEV,
      PH_PTR,
      PH_WDAT,
      PH_RDAT
   } phase_e;

   localparam int NUM_SECT = 9;

   // last address of each section, ascending; the final one is the unmapped range
   localparam logic [7:0] SECT_LAST [NUM_SECT] =
      '{8'h06, 8'h0F, 8'h15, 8'h1A, 8'h1F, 8'h27, 8'h29, 8'h2F, 8'hFF};

   function automatic logic [7:0] sect_first(input int idx);
      if (idx == 0) return 8'h00;
      return SECT_LAST[idx-1] + 8'h01;
   endfunction

endpackage

// File: rtl/secreg_sect.sv
module secreg_sect
   import secreg_pkg::*;
(
   input  logic [7:0] i_addr,
   output logic [7:0] o_next,
   output logic [3:0] o_idx
);

   logic [NUM_SECT-1:0] hit;

   generate
      for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
         if (s == 0) begin : g_low
            assign hit[s] = (i_addr <= SECT_LAST[s]);
         end else begin : g_mid
            assign hit[s] = (i_addr > SECT_LAST[s-1]) && (i_addr <= SECT_LAST[s]);
         end
      end
   endgenerate

   always_comb begin
      o_next = i_addr + 8'h01;
      o_idx  = '0;
      for (int s = 0; s < NUM_SECT; s++) begin
         if (hit[s]) begin
            o_idx = s[3:0];
            if (i_addr == SECT_LAST[s]) o_next = sect_first(s);
         end
      end
   end

endmodule

// File: rtl/secreg_regs.sv
module secreg_regs #(
   parameter int MAP_TOP  = 47,
   parameter int CLK_REGS = 7,
   parameter int WP_ADDR  = 8,
   parameter int WP_BIT   = 6
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        i_we,
   input  logic [7:0]                  i_waddr,
   input  logic [7:0]                  i_wdata,
   input  logic                        i_cal_we,
   input  logic [$clog2(CLK_REGS)-1:0] i_cal_idx,
   input  logic [7:0]                  i_cal_data,
   input  logic                        i_snap,
   input  logic                        i_use_snap,
   input  logic [7:0]                  i_raddr,
   output logic [7:0]                  o_rdata,
   output logic                        o_wp,
   output logic [CLK_REGS*8-1:0]       o_clk_vec,
   output logic [CLK_REGS*8-1:0]       o_shadow_vec
);

   localparam int NBYTES = MAP_TOP + 1;

   logic [NBYTES*8-1:0]   flat;
   logic [CLK_REGS*8-1:0] shadow_q;
   logic                  host_ok;

   assign o_wp    = flat[WP_ADDR*8 + WP_BIT];
   assign host_ok = i_we && (int'(i_waddr) <= MAP_TOP) &&
                    ((int'(i_waddr) >= CLK_REGS) || o_wp);

   generate
      for (genvar g = 0; g < NBYTES; g++) begin : g_byte
         logic [7:0] q;
         if (g < CLK_REGS) begin : g_clk
            always_ff @(posedge clk) begin
               if (!rst_n)                                    q <= '0;
               else if (i_cal_we && int'(i_cal_idx) == g)     q <= i_cal_data;
               else if (host_ok && int'(i_waddr) == g)        q <= i_wdata;
            end
         end else begin : g_plain
            always_ff @(posedge clk) begin
               if (!rst_n)                                    q <= '0;
               else if (host_ok && int'(i_waddr) == g)        q <= i_wdata;
            end
         end
         assign flat[g*8 +: 8] = q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)      shadow_q <= '0;
      else if (i_snap) shadow_q <= flat[CLK_REGS*8-1:0];
   end

   always_comb begin
      o_rdata = 8'h00;
      if (int'(i_raddr) <= MAP_TOP) begin
         if (i_use_snap && int'(i_raddr) < CLK_REGS)
            o_rdata = shadow_q[int'(i_raddr)*8 +: 8];
         else
            o_rdata = flat[int'(i_raddr)*8 +: 8];
      end
   end

   assign o_clk_vec    = flat[CLK_REGS*8-1:0];
   assign o_shadow_vec = shadow_q;

endmodule

// File: rtl/secreg_sram.sv
module secreg_sram #(
   parameter int DEPTH = 128,
   parameter bit CLEAR = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     i_we,
   input  logic [$clog2(DEPTH)-1:0] i_addr,
   input  logic [7:0]               i_wdata,
   output logic [7:0]               o_rdata
);

   logic [7:0] mem [DEPTH];

   generate
      if (CLEAR) begin : g_clear
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
            end else if (i_we) begin
               mem[i_addr] <= i_wdata;
            end
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (i_we && rst_n) mem[i_addr] <= i_wdata;
         end
      end
   endgenerate

   assign o_rdata = mem[i_addr];

endmodule

// File: rtl/secreg_ctrl.sv
module secreg_ctrl
   import secreg_pkg::*;
#(
   parameter logic [6:0] REG_DEV_ID = 7'h6F,
   parameter logic [6:0] MEM_DEV_ID = 7'h57,
   parameter int         MEM_DEPTH  = 128,
   parameter bit         MEM_CLEAR  = 1'b1,
   parameter int         CLK_REGS   = 7,
   parameter int         WP_ADDR    = 8,
   parameter int         WP_BIT     = 6,
   parameter int         MAP_TOP    = 47,
   parameter int         CLK_SECT   = 0,
   parameter int         ALM_SECT   = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        i_start,
   input  logic                        i_stop,
   input  logic                        i_dev_vld,
   input  logic [7:0]                  i_dev_byte,
   output logic                        o_dev_ack,
   input  logic                        i_wr_vld,
   input  logic [7:0]                  i_wr_byte,
   input  logic                        i_rd_req,
   output logic [7:0]                  o_rd_byte,
   input  logic                        i_cal_we,
   input  logic [$clog2(CLK_REGS)-1:0] i_cal_idx,
   input  logic [7:0]                  i_cal_byte
);

   localparam int MAW = $clog2(MEM_DEPTH);

   generate
      if ((1 << MAW) != MEM_DEPTH || MAW > 8 || MAW < 1) begin : g_bad_depth
         $error("MEM_DEPTH must be a power of two from 2 to 256");
      end
      if (MAP_TOP != int'(SECT_LAST[NUM_SECT-2])) begin : g_bad_top
         $error("MAP_TOP must match the last mapped section");
      end
      if (CLK_REGS != int'(SECT_LAST[CLK_SECT]) + 1 || WP_ADDR <= CLK_REGS - 1 || WP_BIT > 7) begin : g_bad_clk
         $error("clock section or protect bit placement is inconsistent");
      end
   endgenerate

   phase_e          ph;
   logic            tgt_mem;
   logic            snap_on;
   logic [7:0]      reg_ptr;
   logic [MAW-1:0]  mem_ptr;
   logic [7:0]      reg_next;
   logic [3:0]      reg_sect;
   logic [7:0]      reg_rdata;
   logic [7:0]      mem_rdata;
   logic            wp_bit;
   logic [CLK_REGS*8-1:0] clk_vec;
   logic [CLK_REGS*8-1:0] shadow_vec;

   logic hit_reg, hit_mem, dev_acc, wr_acc, rd_fire, snap_pulse;
   logic reg_we, mem_we;

   assign hit_reg  = (i_dev_byte[7:1] == REG_DEV_ID);
   assign hit_mem  = (i_dev_byte[7:1] == MEM_DEV_ID);
   assign dev_acc  = (ph == PH_DEV) && i_dev_vld && !i_start && !i_stop;
   assign wr_acc   = i_wr_vld && !i_start && !i_stop && !i_dev_vld;
   assign rd_fire  = (ph == PH_RDAT) && i_rd_req && !i_start && !i_stop &&
                     !i_dev_vld && !i_wr_vld;

   assign o_dev_ack  = dev_acc && (hit_reg || hit_mem);
   assign snap_pulse = dev_acc && hit_reg && i_dev_byte[0] &&
                       ((int'(reg_sect) == CLK_SECT) || (int'(reg_sect) == ALM_SECT));
   assign reg_we     = wr_acc && (ph == PH_WDAT) && !tgt_mem;
   assign mem_we     = wr_acc && (ph == PH_WDAT) && tgt_mem;

   secreg_sect u_sect (
      .i_addr (reg_ptr),
      .o_next (reg_next),
      .o_idx  (reg_sect)
   );

   secreg_regs #(
      .MAP_TOP  (MAP_TOP),
      .CLK_REGS (CLK_REGS),
      .WP_ADDR  (WP_ADDR),
      .WP_BIT   (WP_BIT)
   ) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .i_we         (reg_we),
      .i_waddr      (reg_ptr),
      .i_wdata      (i_wr_byte),
      .i_cal_we     (i_cal_we),
      .i_cal_idx    (i_cal_idx),
      .i_cal_data   (i_cal_byte),
      .i_snap       (snap_pulse),
      .i_use_snap   (snap_on),
      .i_raddr      (reg_ptr),
      .o_rdata      (reg_rdata),
      .o_wp         (wp_bit),
      .o_clk_vec    (clk_vec),
      .o_shadow_vec (shadow_vec)
   );

   secreg_sram #(
      .DEPTH (MEM_DEPTH),
      .CLEAR (MEM_CLEAR)
   ) u_sram (
      .clk     (clk),
      .rst_n   (rst_n),
      .i_we    (mem_we),
      .i_addr  (mem_ptr),
      .i_wdata (i_wr_byte),
      .o_rdata (mem_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph        <= PH_IDLE;
         tgt_mem   <= 1'b0;
         snap_on   <= 1'b0;
         reg_ptr   <= '0;
         mem_ptr   <= '0;
         o_rd_byte <= '0;
      end else if (i_start) begin
         ph      <= PH_DEV;
         snap_on <= 1'b0;
      end else if (i_stop) begin
         ph      <= PH_IDLE;
         snap_on <= 1'b0;
      end else begin
         case (ph)
            PH_DEV: if (i_dev_vld) begin
               if (hit_reg || hit_mem) begin
                  tgt_mem <= hit_mem;
                  ph      <= i_dev_byte[0] ? PH_RDAT : PH_PTR;
                  if (snap_pulse) snap_on <= 1'b1;
               end else begin
                  ph <= PH_IDLE;
               end
            end
            PH_PTR: if (wr_acc) begin
               if (tgt_mem) mem_ptr <= i_wr_byte[MAW-1:0];
               else         reg_ptr <= i_wr_byte;
               ph <= PH_WDAT;
            end
            PH_WDAT: if (wr_acc) begin
               if (tgt_mem) mem_ptr <= mem_ptr + 1'b1;
               else         reg_ptr <= reg_next;
            end
            PH_RDAT: if (rd_fire) begin
               o_rd_byte <= tgt_mem ? mem_rdata : reg_rdata;
               if (tgt_mem) mem_ptr <= mem_ptr + 1'b1;
               else         reg_ptr <= reg_next;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/secreg_chk.sv
module secreg_chk #(
   parameter logic [6:0] REG_DEV_ID = 7'h6F,
   parameter logic [6:0] MEM_DEV_ID = 7'h57,
   parameter int         CLK_REGS   = 7,
   parameter int         MAP_TOP    = 47
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  i_dev_vld,
   input logic [7:0]            i_dev_byte,
   input logic                  o_dev_ack,
   input logic                  rd_fire,
   input logic                  tgt_mem,
   input logic [7:0]            reg_ptr,
   input logic [3:0]            reg_sect,
   input logic [7:0]            o_rd_byte,
   input logic                  wp_bit,
   input logic                  i_cal_we,
   input logic [CLK_REGS*8-1:0] clk_vec,
   input logic                  snap_on,
   input logic                  snap_pulse,
   input logic [CLK_REGS*8-1:0] shadow_vec
);

   // R1: acknowledge only a valid byte carrying one of the two identities
   p_ack_id_r1: assert property (@(posedge clk) disable iff (!rst_n)
      o_dev_ack |-> (i_dev_vld && (i_dev_byte[7:1] == REG_DEV_ID || i_dev_byte[7:1] == MEM_DEV_ID)));

   // R3: a register-map read step never leaves the section
   p_same_sect_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_fire && !tgt_mem) |=> (reg_sect == $past(reg_sect)));

   // R4: clock registers frozen while protected and calendar idle
   p_protect_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!i_cal_we && !wp_bit) |=> $stable(clk_vec));

   // R5: shadow holds during a snapshot transfer
   p_snap_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (snap_on && !snap_pulse) |=> $stable(shadow_vec));

   // R7: unmapped reads yield zero
   p_unmapped_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_fire && !tgt_mem && int'(reg_ptr) > MAP_TOP) |=> (o_rd_byte == 8'h00));

   // R10: read byte moves only on an accepted request
   p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_fire |=> $stable(o_rd_byte));

endmodule

bind secreg_ctrl secreg_chk #(
   .REG_DEV_ID (REG_DEV_ID),
   .MEM_DEV_ID (MEM_DEV_ID),
   .CLK_REGS   (CLK_REGS),
   .MAP_TOP    (MAP_TOP)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .i_dev_vld  (i_dev_vld),
   .i_dev_byte (i_dev_byte),
   .o_dev_ack  (o_dev_ack),
   .rd_fire    (rd_fire),
   .tgt_mem    (tgt_mem),
   .reg_ptr    (reg_ptr),
   .reg_sect   (reg_sect),
   .o_rd_byte  (o_rd_byte),
   .wp_bit     (wp_bit),
   .i_cal_we   (i_cal_we),
   .clk_vec    (clk_vec),
   .snap_on    (snap_on),
   .snap_pulse (snap_pulse),
   .shadow_vec (shadow_vec)
);

// File: tb/secreg_ctrl_tb.sv
module secreg_ctrl_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       i_start = 0, i_stop = 0, i_dev_vld = 0, i_wr_vld = 0, i_rd_req = 0, i_cal_we = 0;
   logic [7:0] i_dev_byte = 0, i_wr_byte = 0, i_cal_byte = 0;
   logic [2:0] i_cal_idx = 0;
   logic       o_dev_ack;
   logic [7:0] o_rd_byte;

   always #2 clk = ~clk;

   secreg_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .i_start(i_start), .i_stop(i_stop),
      .i_dev_vld(i_dev_vld), .i_dev_byte(i_dev_byte), .o_dev_ack(o_dev_ack),
      .i_wr_vld(i_wr_vld), .i_wr_byte(i_wr_byte), .i_rd_req(i_rd_req),
      .o_rd_byte(o_rd_byte), .i_cal_we(i_cal_we), .i_cal_idx(i_cal_idx),
      .i_cal_byte(i_cal_byte)
   );

   int total = 0, bad = 0;
   bit done = 0;

   // behavioural model
   int regs [48];
   int mem [128];
   int shadow [7];
   int phase = 0;      // 0 idle, 1 want dev, 2 want ptr, 3 write data, 4 read data
   int m_tgt = 0;      // 1 = byte memory
   int rptr = 0, mptr = 0;
   bit snap = 0;
   int exp_rd = 0;

   function automatic int first_of(int a);
      if (a < 7)  return 0;
      if (a < 16) return 7;
      if (a < 22) return 16;
      if (a < 27) return 22;
      if (a < 32) return 27;
      if (a < 40) return 32;
      if (a < 42) return 40;
      if (a < 48) return 42;
      return 48;
   endfunction

   function automatic int last_of(int a);
      if (a < 7)  return 6;
      if (a < 16) return 15;
      if (a < 22) return 21;
      if (a < 27) return 26;
      if (a < 32) return 31;
      if (a < 40) return 39;
      if (a < 42) return 41;
      if (a < 48) return 47;
      return 255;
   endfunction

   function automatic int step(int a);
      return (a == last_of(a)) ? first_of(a) : a + 1;
   endfunction

   task automatic check(string req, int act, int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // every cycle: registered read byte against the model
   always @(posedge clk) begin
      #1;
      if (rst_n && !done) check("R10 per-cycle read byte", int'(o_rd_byte), exp_rd);
   end

   task automatic ev_start();
      @(negedge clk); i_start = 1; phase = 1; snap = 0;
      @(negedge clk); i_start = 0;
   endtask

   task automatic ev_stop();
      @(negedge clk); i_stop = 1; phase = 0; snap = 0;
      @(negedge clk); i_stop = 0;
   endtask

   task automatic ev_dev(logic [7:0] b);
      int exp_ack;
      bit is_reg, is_mem;
      is_reg = (b[7:1] == 7'b1101111);
      is_mem = (b[7:1] == 7'b1010111);
      exp_ack = (phase == 1 && (is_reg || is_mem)) ? 1 : 0;
      @(negedge clk); i_dev_vld = 1; i_dev_byte = b;
      #1 check("R1 device ack", int'(o_dev_ack), exp_ack);
      if (phase == 1) begin
         if (is_reg || is_mem) begin
            m_tgt = is_mem;
            if (b[0] && is_reg && (rptr < 7 || (rptr >= 16 && rptr < 22))) begin
               snap = 1;
               for (int k = 0; k < 7; k++) shadow[k] = regs[k];
            end
            phase = b[0] ? 4 : 2;
         end else phase = 0;
      end
      @(negedge clk); i_dev_vld = 0;
   endtask

   task automatic ev_wr(logic [7:0] b);
      @(negedge clk); i_wr_vld = 1; i_wr_byte = b;
      if (phase == 2) begin
         if (m_tgt) mptr = b % 128; else rptr = b;
         phase = 3;
      end else if (phase == 3) begin
         if (m_tgt) begin
            mem[mptr] = b; mptr = (mptr + 1) % 128;
         end else begin
            if (rptr < 48 && (rptr >= 7 || regs[8][6])) regs[rptr] = b;
            rptr = step(rptr);
         end
      end
      @(negedge clk); i_wr_vld = 0;
   endtask

   task automatic ev_rd(string req);
      @(negedge clk); i_rd_req = 1;
      if (phase == 4) begin
         if (m_tgt) begin
            exp_rd = mem[mptr]; mptr = (mptr + 1) % 128;
         end else begin
            if (rptr >= 48) exp_rd = 0;
            else if (snap && rptr < 7) exp_rd = shadow[rptr];
            else exp_rd = regs[rptr];
            rptr = step(rptr);
         end
      end
      @(negedge clk); i_rd_req = 0;
      check(req, int'(o_rd_byte), exp_rd);
   endtask

   task automatic ev_cal(int idx, logic [7:0] b);
      @(negedge clk); i_cal_we = 1; i_cal_idx = idx[2:0]; i_cal_byte = b;
      regs[idx] = b;
      @(negedge clk); i_cal_we = 0;
   endtask

   task automatic wr_burst(logic [7:0] dev, logic [7:0] p, logic [7:0] d0, logic [7:0] d1, int n);
      ev_start(); ev_dev(dev); ev_wr(p);
      if (n > 0) ev_wr(d0);
      if (n > 1) ev_wr(d1);
      ev_stop();
   endtask

   task automatic open_read(logic [7:0] dev, logic [7:0] p);
      ev_start(); ev_dev(dev); ev_wr(p);
      ev_start(); ev_dev(dev | 8'h01);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1; total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < 48; k++) regs[k] = 0;
      for (int k = 0; k < 128; k++) mem[k] = 0;
      repeat (4) @(negedge clk);
      check("R10 reset read byte", int'(o_rd_byte), 0);
      check("R1 reset ack", int'(o_dev_ack), 0);
      rst_n = 1;

      // R1: identities and an unmatched transfer
      ev_start(); ev_dev(8'h90); ev_wr(8'h05); ev_wr(8'h11); ev_rd("R1 unmatched read holds"); ev_stop();
      ev_dev(8'hDE);  // outside a transfer: no ack
      ev_start(); ev_dev(8'hAE); ev_stop();

      // R4: protected clock write discarded, then released
      wr_burst(8'hDE, 8'h02, 8'h55, 8'h00, 1);
      open_read(8'hDE, 8'h02); ev_rd("R4 protected write discarded"); ev_stop();
      wr_burst(8'hDE, 8'h08, 8'h40, 8'h00, 1);
      wr_burst(8'hDE, 8'h06, 8'h66, 8'h99, 2);   // R3 wrap 06 -> 00
      open_read(8'hDE, 8'h06); ev_rd("R4 released write"); ev_rd("R3 clock wrap write"); ev_stop();

      // R2/R3: control section burst across its end
      ev_start(); ev_dev(8'hDE); ev_wr(8'h0E); ev_wr(8'hA1); ev_wr(8'hA2); ev_wr(8'hA3); ev_stop();
      open_read(8'hDE, 8'h0E);
      ev_rd("R2 burst byte 0"); ev_rd("R3 last of control"); ev_rd("R3 wrapped to 07"); ev_rd("R2 protect reg kept");
      ev_stop();
      // R6: current-address read continues at 09
      ev_start(); ev_dev(8'hDF); ev_rd("R6 current address read"); ev_stop();

      // R5/R9: snapshot against calendar updates
      ev_cal(0, 8'h10); ev_cal(1, 8'h21); ev_cal(2, 8'h32); ev_cal(3, 8'h43);
      open_read(8'hDE, 8'h00);
      ev_rd("R5 snapshot byte 0");
      ev_cal(1, 8'h77); ev_cal(2, 8'h88); ev_cal(0, 8'h99);
      ev_rd("R5 snapshot byte 1"); ev_rd("R5 snapshot byte 2"); ev_rd("R5 snapshot byte 3");
      ev_stop();
      open_read(8'hDE, 8'h00); ev_rd("R9 calendar value 0"); ev_rd("R9 calendar value 1"); ev_stop();
      // alarm-start read also snapshots; calendar writes are ignored by the protect bit
      wr_burst(8'hDE, 8'h08, 8'h00, 8'h00, 1);
      ev_cal(4, 8'h5A);
      open_read(8'hDE, 8'h14); ev_rd("R3 alarm 14"); ev_rd("R3 alarm 15"); ev_rd("R3 alarm wrap 10"); ev_stop();
      open_read(8'hDE, 8'h04); ev_rd("R9 cal ignores protect"); ev_stop();

      // R3/R7: scratch wrap and unmapped range
      wr_burst(8'hDE, 8'h2F, 8'hC1, 8'hC2, 2);
      open_read(8'hDE, 8'h2F); ev_rd("R3 scratch last"); ev_rd("R3 scratch wrap 2A"); ev_stop();
      wr_burst(8'hDE, 8'h30, 8'h77, 8'h00, 1);
      open_read(8'hDE, 8'hFF); ev_rd("R7 unmapped FF"); ev_rd("R7 unmapped wrap 30"); ev_stop();

      // R8: byte memory with wrap and independent pointers
      ev_start(); ev_dev(8'hAE); ev_wr(8'h7E); ev_wr(8'h01); ev_wr(8'h02); ev_wr(8'h03); ev_stop();
      open_read(8'hAE, 8'h7E); ev_rd("R8 mem 7E"); ev_rd("R8 mem 7F"); ev_rd("R8 mem wrap 00"); ev_stop();
      ev_start(); ev_dev(8'hDF); ev_rd("R8 reg pointer untouched"); ev_stop();
      ev_start(); ev_dev(8'hAF); ev_rd("R6 mem current address"); ev_stop();

      repeat (3) @(negedge clk);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule